// File: doc/BRIEF.md
# Bitfield extract/insert unit

This execution unit serves a 64-bit integer pipeline. It pulls a contiguous bit field out of a source register, or writes the low bits of a source register into a field of an existing destination value. Each operation takes one clock. The caller presents a function code, two 5-bit immediates and the two register operands together with a valid strobe. A clock later the unit returns a 64-bit result, a valid flag and a write-enable.

There are eight forms. Four of them extract and four of them insert. Word forms work on the low 32 bits and sign-extend their result. The other forms add a bias of 32 to the low bound, to the high bound, or to both, so that fields reaching into the upper word can be encoded with 5-bit immediates. When an insert form has an empty field, the write-enable is dropped and the old destination value is passed through unchanged.

Top module: `bfx_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `out_valid` at that edge. The clear happens even if `in_valid` is high.
- R2: `out_valid` equals the `in_valid` seen at the previous clock edge. `out_result` and `out_wen` belong to the operands presented at that edge.
- R3: While `in_valid` is low, `out_result` and `out_wen` keep their values whatever happens on the other inputs.
- R4: `out_wen` is 1 for every extract form and for every insert form whose field is not empty.
- R5: Function code 000011 (double extract) returns `in_rs[lsb+size : lsb]` right-aligned with zeros above. Here `lsb` is `in_lo_fld` and `size` is `in_hi_fld`.
- R6: Function code 000001 (extract, width biased by 32) returns `in_rs[lsb+size+32 : lsb]` right-aligned. Source bits past bit 63 read as zero.
- R7: Function code 000010 (extract, position biased by 32) returns `in_rs[lsb+32+size : lsb+32]` right-aligned. Source bits past bit 63 read as zero.
- R8: Function code 000000 (word extract) takes `in_rs[lsb+size : lsb]` from the low word, with bits past 31 reading as zero. It right-aligns that field in 32 bits and sign-extends bit 31 to 64 bits.
- R9: Function code 000111 (double insert) replaces `in_rt[msb:lsb]` with the low bits of `in_rs`, where `msb` is `in_hi_fld`. All other bits of `in_rt` are kept. Function code 000100 does the same on the low word and then sign-extends bit 31.
- R10: Function code 000101 inserts into `in_rt[msb+32 : lsb]`. Function code 000110 inserts into `in_rt[msb+32 : lsb+32]`. In both cases the field is filled from the low bits of `in_rs` and all other bits are kept.
- R11: For codes 000100, 000111 and 000110, lsb > msb makes the field empty. In that case `out_wen` is 0 and `out_result` equals `in_rt`. Code 000101 is never empty.
- R12: Any other function code gives `out_wen` = 0 and `out_result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_func | input | 6 | Function code selecting the form |
| in_hi_fld | input | 5 | Size immediate (extract) or high-bound immediate (insert) |
| in_lo_fld | input | 5 | Low-bound immediate |
| in_rs | input | 64 | Source register value |
| in_rt | input | 64 | Old destination register value |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | 64 | Registered result |
| out_wen | output | 1 | Register write-enable for the result |

## Verification
The eight function codes are each swept over every combination of the two immediates. The sweep runs once with random operands, which exposes a wrong bias, a wrong bound or a wrong source shift. It runs again with an all-ones source over a zero destination, which shows the exact field mask and the zero-fill of out-of-range bits; there, sign extension of word forms appears as a solid upper word. Every unused function code is applied to confirm the no-write path. Separate runs drop the strobe while the operands change, and assert reset during an active strobe.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  localparam int XLEN   = 64;
  localparam int WLEN   = 32;
  localparam int IMM_W  = 5;
  localparam int FUNC_W = 6;
  localparam int POS_W  = 7;
  localparam int BIAS   = WLEN;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_EXT  = 2'd1,
    K_INS  = 2'd2
  } kind_e;

  // Function codes (low six bits of the instruction word)
  localparam logic [FUNC_W-1:0] F_EXT_W  = 6'b000000;
  localparam logic [FUNC_W-1:0] F_EXT_WB = 6'b000001;
  localparam logic [FUNC_W-1:0] F_EXT_PB = 6'b000010;
  localparam logic [FUNC_W-1:0] F_EXT_D  = 6'b000011;
  localparam logic [FUNC_W-1:0] F_INS_W  = 6'b000100;
  localparam logic [FUNC_W-1:0] F_INS_HB = 6'b000101;
  localparam logic [FUNC_W-1:0] F_INS_BB = 6'b000110;
  localparam logic [FUNC_W-1:0] F_INS_D  = 6'b000111;

  typedef struct packed {
    kind_e             kind;
    logic              word;
    logic [POS_W-1:0]  lo;
    logic [POS_W-1:0]  hi;
    logic [POS_W-1:0]  width;
    logic              empty;
  } bf_ctl_t;

  // Mask with the n lowest bits set (saturates at XLEN)
  function automatic logic [XLEN-1:0] low_ones(input logic [POS_W-1:0] n);
    if (n >= POS_W'(XLEN)) return '1;
    return ~({XLEN{1'b1}} << n);
  endfunction

  // Mask covering bit positions lo..hi, clipped to the register
  function automatic logic [XLEN-1:0] span_mask(input logic [POS_W-1:0] lo,
                                                input logic [POS_W-1:0] hi);
    logic [POS_W-1:0] top;
    if (lo > hi || lo >= POS_W'(XLEN)) return '0;
    top = (hi >= POS_W'(XLEN - 1)) ? POS_W'(XLEN - 1) : hi;
    return low_ones(top + POS_W'(1)) & ~low_ones(lo);
  endfunction

  // Right-aligned field of the given width starting at lo
  function automatic logic [XLEN-1:0] pull_field(input logic [XLEN-1:0]  v,
                                                 input logic [POS_W-1:0] lo,
                                                 input logic [POS_W-1:0] width);
    return (v >> lo) & low_ones(width);
  endfunction

  // Old value with bits lo..hi taken from src shifted up by lo
  function automatic logic [XLEN-1:0] merge_field(input logic [XLEN-1:0]  old,
                                                  input logic [XLEN-1:0]  src,
                                                  input logic [POS_W-1:0] lo,
                                                  input logic [POS_W-1:0] hi);
    logic [XLEN-1:0] m;
    m = span_mask(lo, hi);
    return (old & ~m) | ((src << lo) & m);
  endfunction

  function automatic logic [XLEN-1:0] widen_word(input logic [WLEN-1:0] w);
    return {{(XLEN-WLEN){w[WLEN-1]}}, w};
  endfunction

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic [IMM_W-1:0]  hi_fld,
  input  logic [IMM_W-1:0]  lo_fld,
  output bf_ctl_t           ctl
);

  localparam logic [POS_W-1:0] BIAS_P = POS_W'(BIAS);

  logic [POS_W-1:0] lsb_p;
  logic [POS_W-1:0] top_p;

  assign lsb_p = POS_W'(lo_fld);
  assign top_p = POS_W'(hi_fld);

  always_comb begin
    ctl = '{kind: K_NONE, word: 1'b0, lo: '0, hi: '0, width: '0, empty: 1'b0};
    unique case (func)
      F_EXT_W: begin
        ctl.kind = K_EXT; ctl.word = 1'b1;
        ctl.lo = lsb_p; ctl.hi = lsb_p + top_p;
      end
      F_EXT_D: begin
        ctl.kind = K_EXT;
        ctl.lo = lsb_p; ctl.hi = lsb_p + top_p;
      end
      F_EXT_WB: begin
        ctl.kind = K_EXT;
        ctl.lo = lsb_p; ctl.hi = lsb_p + top_p + BIAS_P;
      end
      F_EXT_PB: begin
        ctl.kind = K_EXT;
        ctl.lo = lsb_p + BIAS_P; ctl.hi = lsb_p + BIAS_P + top_p;
      end
      F_INS_W: begin
        ctl.kind = K_INS; ctl.word = 1'b1;
        ctl.lo = lsb_p; ctl.hi = top_p;
      end
      F_INS_D: begin
        ctl.kind = K_INS;
        ctl.lo = lsb_p; ctl.hi = top_p;
      end
      F_INS_HB: begin
        ctl.kind = K_INS;
        ctl.lo = lsb_p; ctl.hi = top_p + BIAS_P;
      end
      F_INS_BB: begin
        ctl.kind = K_INS;
        ctl.lo = lsb_p + BIAS_P; ctl.hi = top_p + BIAS_P;
      end
      default: ;
    endcase
    if (ctl.kind == K_EXT) ctl.width = ctl.hi - ctl.lo + POS_W'(1);
    ctl.empty = (ctl.kind == K_INS) && (ctl.lo > ctl.hi);
  end

endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            chk_en,
  input  bf_ctl_t         ctl,
  input  logic [XLEN-1:0] rs,
  input  logic [XLEN-1:0] rt,
  output logic [XLEN-1:0] res,
  output logic            wen
);

  logic [XLEN-1:0] ext_src;
  logic [XLEN-1:0] ext_val;
  logic [XLEN-1:0] ins_val;
  logic            ext_fire;
  logic            ins_fire;
  logic            ins_skip;

  assign ext_fire = (ctl.kind == K_EXT);
  assign ins_fire = (ctl.kind == K_INS) && !ctl.empty;
  assign ins_skip = (ctl.kind == K_INS) && ctl.empty;

  // Word extract sees only the low word; upper source bits read as zero
  assign ext_src = ctl.word ? {{(XLEN-WLEN){1'b0}}, rs[WLEN-1:0]} : rs;
  assign ext_val = pull_field(ext_src, ctl.lo, ctl.width);
  assign ins_val = merge_field(rt, rs, ctl.lo, ctl.hi);

  always_comb begin
    res = '0;
    wen = 1'b0;
    if (ext_fire) begin
      res = ctl.word ? widen_word(ext_val[WLEN-1:0]) : ext_val;
      wen = 1'b1;
    end else if (ins_fire) begin
      res = ctl.word ? widen_word(ins_val[WLEN-1:0]) : ins_val;
      wen = 1'b1;
    end else if (ins_skip) begin
      res = rt;
    end
  end

  // R11
  empty_keeps_rt_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en && ins_skip |-> (res == rt) && !wen);

  // R5
  ext_zero_above_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en && ext_fire && !ctl.word && (ctl.width < POS_W'(XLEN))
      |-> ((res >> ctl.width) == '0));

  // R8
  word_ext_top_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en && ext_fire && ctl.word && (ctl.width < POS_W'(WLEN))
      |-> (res[XLEN-1:WLEN-1] == '0));

  // R9
  ins_below_lo_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en && ins_fire && !ctl.word |-> (((res ^ rt) & low_ones(ctl.lo)) == '0));

  // R12
  unknown_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en && (ctl.kind == K_NONE) |-> !wen && (res == '0));

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [IMM_W-1:0]  in_hi_fld,
  input  logic [IMM_W-1:0]  in_lo_fld,
  input  logic [XLEN-1:0]   in_rs,
  input  logic [XLEN-1:0]   in_rt,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_result,
  output logic              out_wen
);

  bf_ctl_t         ctl;
  logic [XLEN-1:0] dp_res;
  logic            dp_wen;

  bfx_decode u_decode (
    .func   (in_func),
    .hi_fld (in_hi_fld),
    .lo_fld (in_lo_fld),
    .ctl    (ctl)
  );

  bfx_datapath u_datapath (
    .clk    (clk),
    .rst    (rst),
    .chk_en (in_valid),
    .ctl    (ctl),
    .rs     (in_rs),
    .rt     (in_rt),
    .res    (dp_res),
    .wen    (dp_wen)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_result <= dp_res;
      out_wen    <= dp_wen;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R2
  valid_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result) && $stable(out_wen));

endmodule

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  in_func = '0;
  logic [4:0]  in_hi_fld = '0;
  logic [4:0]  in_lo_fld = '0;
  logic [63:0] in_rs = '0;
  logic [63:0] in_rt = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_wen;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfx_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_func(in_func),
    .in_hi_fld(in_hi_fld), .in_lo_fld(in_lo_fld), .in_rs(in_rs), .in_rt(in_rt),
    .out_valid(out_valid), .out_result(out_result), .out_wen(out_wen)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] f);
    case (f)
      6'b000011: return "R5";
      6'b000001: return "R6";
      6'b000010: return "R7";
      6'b000000: return "R8";
      6'b000100, 6'b000111: return "R9";
      6'b000101, 6'b000110: return "R10";
      default: return "R12";
    endcase
  endfunction

  // Bit-by-bit model written from the requirements
  task automatic model(input logic [5:0] f, input int a, input int b,
                       input logic [63:0] rs, input logic [63:0] rt,
                       output logic [63:0] exp, output bit ewen, output bit empty);
    int lo, hi, lim;
    bit is_ext, is_ins, word;
    is_ext = 0; is_ins = 0; word = 0; lo = 0; hi = 0; lim = 64; empty = 0;
    case (f)
      6'b000011: begin is_ext = 1; lo = b;      hi = b + a;      end
      6'b000001: begin is_ext = 1; lo = b;      hi = b + a + 32; end
      6'b000010: begin is_ext = 1; lo = b + 32; hi = b + 32 + a; end
      6'b000000: begin is_ext = 1; lo = b;      hi = b + a; word = 1; lim = 32; end
      6'b000111: begin is_ins = 1; lo = b;      hi = a;      end
      6'b000100: begin is_ins = 1; lo = b;      hi = a; word = 1; end
      6'b000101: begin is_ins = 1; lo = b;      hi = a + 32; end
      6'b000110: begin is_ins = 1; lo = b + 32; hi = a + 32; end
      default: ;
    endcase
    exp = '0; ewen = 0;
    if (is_ext) begin
      ewen = 1;
      for (int i = 0; i < 64; i++)
        if (lo + i <= hi && lo + i < lim) exp[i] = rs[lo + i];
      if (word) exp[63:32] = {32{exp[31]}};
    end else if (is_ins) begin
      if (lo > hi) begin
        empty = 1; exp = rt;
      end else begin
        ewen = 1;
        for (int i = 0; i < 64; i++)
          exp[i] = (i >= lo && i <= hi) ? rs[i - lo] : rt[i];
        if (word) exp[63:32] = {32{exp[31]}};
      end
    end
  endtask

  task automatic apply_and_check(input logic [5:0] f, input int a, input int b,
                                 input logic [63:0] rs, input logic [63:0] rt);
    logic [63:0] exp;
    bit ewen, empty;
    string tg;
    model(f, a, b, rs, rt, exp, ewen, empty);
    @(negedge clk);
    in_valid = 1; in_func = f; in_hi_fld = 5'(a); in_lo_fld = 5'(b);
    in_rs = rs; in_rt = rt;
    @(posedge clk); #1;
    tg = empty ? "R11" : tag_of(f);
    check(out_valid === 1'b1, "R2 valid", {63'b0, out_valid}, 64'd1);
    check(out_result === exp, tg, out_result, exp);
    check(out_wen === ewen, empty ? "R11 wen" : (ewen ? "R4 wen" : "R12 wen"),
          {63'b0, out_wen}, {63'b0, ewen});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] codes [8];
    logic [63:0] held;
    bit held_wen;
    codes = '{6'b000000, 6'b000001, 6'b000010, 6'b000011,
              6'b000100, 6'b000101, 6'b000110, 6'b000111};

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(out_valid === 1'b0, "R1 reset", {63'b0, out_valid}, 64'd0);
    @(negedge clk); rst = 0;

    // Sweep with random operands
    foreach (codes[k])
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          apply_and_check(codes[k], a, b, {$urandom, $urandom}, {$urandom, $urandom});

    // Sweep with all-ones source over zero destination
    foreach (codes[k])
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          apply_and_check(codes[k], a, b, '1, '0);

    // Corner: lsb=0, size=31 on word extract with sign bit set (R8)
    apply_and_check(6'b000000, 31, 0, 64'h1234_5678_8000_0001, 64'h0);

    // R12: every unused function code
    for (int f = 8; f < 64; f++)
      apply_and_check(6'(f), f % 32, (f * 7) % 32, {$urandom, $urandom}, {$urandom, $urandom});

    // R3: hold while idle
    apply_and_check(6'b000111, 20, 4, 64'hFFFF_0000_FFFF_0000, 64'h0123_4567_89AB_CDEF);
    held = out_result; held_wen = out_wen;
    @(negedge clk);
    in_valid = 0; in_func = 6'b111111; in_rs = '0; in_rt = '1; in_lo_fld = 5'd9;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R2 idle valid", {63'b0, out_valid}, 64'd0);
    check(out_result === held, "R3 hold result", out_result, held);
    check(out_wen === held_wen, "R3 hold wen", {63'b0, out_wen}, {63'b0, held_wen});

    // R1: reset during an active strobe
    @(negedge clk);
    in_valid = 1; in_func = 6'b000011; rst = 1;
    @(posedge clk); #1;
    check(out_valid === 1'b0, "R1 reset with strobe", {63'b0, out_valid}, 64'd0);
    @(negedge clk); rst = 0; in_valid = 0;
    @(posedge clk); #1;
    check(out_valid === 1'b0, "R1 after reset", {63'b0, out_valid}, 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule